// File: doc/BRIEF.md
# Multi-Queue Inter-Processor Mailbox

This block lets several processors on a chip pass 32-bit messages to each other through a bank of small hardware queues. It sits on a simple register bus with an address, a write strobe with write data, and a read strobe with read data. Each queue has one message address. A write there appends a word, and a read there returns the oldest word and removes it. Per-queue registers report whether the queue is full and how many words it holds.

Each processor that takes part (a "client") has its own event status register and event enable register. For every queue these hold two event bits: one that records that a message arrived and one that records that the queue stopped being full. A client's interrupt line is high while any of its enabled events is pending. Events are cleared by writing ones to the status register.

A parameter chooses between two layouts for the per-client registers. The compact layout has a status word and an enable word per client, and software clears an enable with a read-modify-write. The split layout adds a third word per client that clears enables directly.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty, every status and enable bit is 0, all interrupt outputs are low, and address 0x000 reads the constant REVISION (default 0x0000_0201).
- R2: For queue m, address 0x040+4m is the message port, address 0x080+4m reads 1 in bit 0 while the queue holds DEPTH words (0 otherwise), and address 0x0C0+4m reads the number of stored words.
- R3: Reads of a message port return words in the order they were written, and each read removes one word.
- R4: A write to a full queue is dropped and leaves its content and count unchanged. A read of an empty queue returns 0 and leaves the queue unchanged, so a later write and read still return the written word.
- R5: Each accepted write to queue m sets status bit 2m of every client.
- R6: A read that takes queue m from full to not full sets status bit 2m+1 of every client.
- R7: Writing a 1 to a status bit clears it, and a read of the status register on the next access already shows the cleared value. Bits written 0 and other clients' status registers are unchanged.
- R8: irq[u] is high exactly when client u has a bit that is set in both its status and its enable register.
- R9: With INTR_LAYOUT=1, client u has status at 0x104+0x10u, enable at 0x108+0x10u and enable-clear at 0x10C+0x10u. A write to enable ORs the written bits into the enables, a write of ones to enable-clear clears those enables, and enable-clear reads back the current enables.
- R10: With INTR_LAYOUT=0, client u has status at 0x100+8u and enable at 0x104+8u, and a write to enable replaces all of its bits.
- R11: The revision word is read-only: a write to 0x000 does not change what it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address of the register being accessed |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe; a read of a message port removes a word at the clock edge |
| rd_data | output | DW | Read data for addr, valid in the same cycle |
| irq | output | NC | One interrupt line per client |

## Verification
The hardest event to reach from the ports is the not-full event. It happens only on the single read that takes a queue from DEPTH words down to DEPTH-1. The bench fills one queue until it is full, then tries one more write, which must be dropped. It then reads one word back and looks for bit 2m+1 in several clients' status registers. It keeps draining the queue past empty to show that the read pointer wraps and that an empty read moves no pointer. The compact layout is checked on a second instance that shares the bus, after a fresh reset.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int          NQ          = 8,
  parameter int          NC          = 4,
  parameter int          DEPTH       = 4,
  parameter int          DW          = 32,
  parameter int          AW          = 12,
  parameter int          INTR_LAYOUT = 1,
  parameter logic [31:0] REVISION    = 32'h0000_0201
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [NC-1:0] irq
);
  localparam int EW = 2 * NQ;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] msg_a(input int m);
    return AW'(32'h040 + 4 * m);
  endfunction
  function automatic logic [AW-1:0] full_a(input int m);
    return AW'(32'h080 + 4 * m);
  endfunction
  function automatic logic [AW-1:0] cnt_a(input int m);
    return AW'(32'h0C0 + 4 * m);
  endfunction
  function automatic logic [AW-1:0] stat_a(input int u);
    return (INTR_LAYOUT != 0) ? AW'(32'h104 + 16 * u) : AW'(32'h100 + 8 * u);
  endfunction
  function automatic logic [AW-1:0] en_a(input int u);
    return (INTR_LAYOUT != 0) ? AW'(32'h108 + 16 * u) : AW'(32'h104 + 8 * u);
  endfunction
  function automatic logic [AW-1:0] clr_a(input int u);
    return AW'(32'h10C + 16 * u);
  endfunction
  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DW-1:0]          mem [NQ][DEPTH];
  logic [PW-1:0]          wp  [NQ];
  logic [PW-1:0]          rp  [NQ];
  logic [NQ-1:0][CW-1:0]  cnt;
  logic [NQ-1:0]          full, push, pop;
  logic [EW-1:0]          evt;
  logic [NC-1:0][EW-1:0]  stat, en;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign full[q]      = (cnt[q] == CW'(DEPTH));
    assign push[q]      = wr_en && (addr == msg_a(q)) && !full[q];
    assign pop[q]       = rd_en && (addr == msg_a(q)) && (cnt[q] != '0);
    assign evt[2*q]     = push[q];
    assign evt[2*q+1]   = pop[q] && full[q];

    always_ff @(posedge clk)
      if (push[q]) mem[q][wp[q]] <= wr_data;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp[q]  <= '0;
        rp[q]  <= '0;
        cnt[q] <= '0;
      end else begin
        if (push[q]) wp[q] <= nxt(wp[q]);
        if (pop[q])  rp[q] <= nxt(rp[q]);
        if (push[q] && !pop[q])      cnt[q] <= cnt[q] + 1'b1;
        else if (pop[q] && !push[q]) cnt[q] <= cnt[q] - 1'b1;
      end
    end
  end

  for (genvar u = 0; u < NC; u++) begin : g_u
    logic st_wr, en_wr, cl_wr;
    assign st_wr = wr_en && (addr == stat_a(u));
    assign en_wr = wr_en && (addr == en_a(u));
    assign cl_wr = wr_en && (INTR_LAYOUT != 0) && (addr == clr_a(u));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat[u] <= '0;
        en[u]   <= '0;
      end else begin
        stat[u] <= (stat[u] & ~(st_wr ? wr_data[EW-1:0] : '0)) | evt;
        if (INTR_LAYOUT != 0) begin
          if (en_wr)      en[u] <= en[u] | wr_data[EW-1:0];
          else if (cl_wr) en[u] <= en[u] & ~wr_data[EW-1:0];
        end else if (en_wr) begin
          en[u] <= wr_data[EW-1:0];
        end
      end
    end

    assign irq[u] = |(stat[u] & en[u]);
  end

  always_comb begin
    rd_data = '0;
    if (addr == '0) rd_data = DW'(REVISION);
    for (int q = 0; q < NQ; q++) begin
      if (addr == msg_a(q))  rd_data = (cnt[q] != '0) ? mem[q][rp[q]] : '0;
      if (addr == full_a(q)) rd_data = DW'(full[q]);
      if (addr == cnt_a(q))  rd_data = DW'(cnt[q]);
    end
    for (int u = 0; u < NC; u++) begin
      if (addr == stat_a(u)) rd_data = DW'(stat[u]);
      if (addr == en_a(u))   rd_data = DW'(en[u]);
      if ((INTR_LAYOUT != 0) && (addr == clr_a(u))) rd_data = DW'(en[u]);
    end
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int NQ = 8,
  parameter int NC = 4,
  parameter int DEPTH = 4,
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int CW = 3,
  parameter int EW = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [AW-1:0]         addr,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [DW-1:0]         rd_data,
  input logic [NC-1:0]         irq,
  input logic [NQ-1:0][CW-1:0] cnt,
  input logic [NC-1:0][EW-1:0] stat,
  input logic [NC-1:0][EW-1:0] en
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam logic [AW-1:0] MA = AW'(32'h040 + 4 * q);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[q] <= CW'(DEPTH));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && addr == MA && cnt[q] == CW'(DEPTH)) |=> $stable(cnt[q]));

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == MA && cnt[q] == '0) |-> (rd_data == '0));

    for (genvar u = 0; u < NC; u++) begin : g_u
      // R5
      newmsg_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MA && cnt[q] != CW'(DEPTH)) |=> stat[u][2*q]);

      // R6
      notfull_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == MA && cnt[q] == CW'(DEPTH)) |=> stat[u][2*q+1]);
    end
  end

  for (genvar u = 0; u < NC; u++) begin : g_u
    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en[u] == '0) |-> !irq[u]);
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .NQ(NQ), .NC(NC), .DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW), .EW(EW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .irq(irq), .cnt(cnt), .stat(stat), .en(en)
);

// File: tb/ipc_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipc_mailbox_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] addr = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd1, rd0;
  logic [3:0]  irq1, irq0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox #(.INTR_LAYOUT(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd1), .irq(irq1));

  ipc_mailbox #(.INTR_LAYOUT(0)) dut_l0_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd0), .irq(irq0));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, input bit l0, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = l0 ? rd0 : rd1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    do_reset();
    #1 chk("R1 irq after reset", {28'b0, irq1}, 32'h0);
    rd(12'h000, 0, d); chk("R1 revision", d, 32'h0000_0201);
    rd(12'h0C0, 0, d); chk("R1 count q0", d, 32'h0);
    rd(12'h104, 0, d); chk("R1 status u0", d, 32'h0);
    rd(12'h108, 0, d); chk("R1 enable u0", d, 32'h0);
  endtask

  task automatic test_rev_ro();
    logic [31:0] d;
    wr(12'h000, 32'hDEAD_BEEF);
    rd(12'h000, 0, d); chk("R11 revision after write", d, 32'h0000_0201);
  endtask

  task automatic test_order();
    logic [31:0] d;
    wr(12'h048, 32'h1111_0001);
    wr(12'h048, 32'h2222_0002);
    wr(12'h048, 32'h3333_0003);
    rd(12'h0C8, 0, d); chk("R2 count q2", d, 32'd3);
    rd(12'h088, 0, d); chk("R2 full flag q2 not full", d, 32'h0);
    rd(12'h048, 0, d); chk("R3 first word q2", d, 32'h1111_0001);
    rd(12'h048, 0, d); chk("R3 second word q2", d, 32'h2222_0002);
    rd(12'h0C8, 0, d); chk("R3 count after pops", d, 32'd1);
    rd(12'h104, 0, d); chk("R5 newmsg bit4 u0", d & 32'h10, 32'h10);
  endtask

  task automatic test_full_empty();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(12'h054, 32'hA000_0000 + i);
    rd(12'h094, 0, d); chk("R2 full flag q5", d, 32'h1);
    wr(12'h054, 32'hBAD0_BAD0);
    rd(12'h0D4, 0, d); chk("R4 count after dropped write", d, 32'd4);
    rd(12'h114, 0, d); chk("R6 no notfull before pop", d & 32'h800, 32'h0);
    rd(12'h054, 0, d); chk("R3 oldest q5", d, 32'hA000_0000);
    rd(12'h114, 0, d); chk("R6 notfull bit11 u1", d & 32'h800, 32'h800);
    rd(12'h134, 0, d); chk("R6 notfull bit11 u3", d & 32'h800, 32'h800);
    rd(12'h124, 0, d); chk("R5 newmsg bit10 u2", d & 32'h400, 32'h400);
    for (int i = 1; i < 4; i++) begin
      rd(12'h054, 0, d); chk("R4 drained word not overwritten", d, 32'hA000_0000 + i);
    end
    rd(12'h054, 0, d); chk("R4 empty read returns 0", d, 32'h0);
    rd(12'h0D4, 0, d); chk("R4 count stays 0", d, 32'h0);
    wr(12'h054, 32'h5555_AAAA);
    rd(12'h054, 0, d); chk("R4 pointers intact after empty read", d, 32'h5555_AAAA);
    wr(12'h114, 32'hFFFF_FFFF);
    rd(12'h114, 0, d); chk("R7 status u1 cleared", d, 32'h0);
    rd(12'h134, 0, d); chk("R7 status u3 untouched", d & 32'h800, 32'h800);
    wr(12'h134, 32'h0000_0400);
    rd(12'h134, 0, d); chk("R7 only written bit cleared", d & 32'hC00, 32'h800);
  endtask

  task automatic test_irq_l1();
    logic [31:0] d;
    for (int u = 0; u < 4; u++) wr(12'(32'h104 + 16 * u), 32'hFFFF_FFFF);
    wr(12'h128, 32'h0000_0040);
    wr(12'h128, 32'h0000_0001);
    rd(12'h128, 0, d); chk("R9 enable write ORs", d, 32'h41);
    #1 chk("R8 no irq without status", {28'b0, irq1}, 32'h0);
    wr(12'h04C, 32'h0000_0033);
    #1 chk("R8 irq u2 on q3 message", {28'b0, irq1}, 32'h4);
    wr(12'h12C, 32'h0000_0040);
    rd(12'h12C, 0, d); chk("R9 enable-clear reads enables", d, 32'h01);
    #1 chk("R9 irq drops after enable clear", {28'b0, irq1}, 32'h0);
    wr(12'h040, 32'h0000_0077);
    #1 chk("R8 irq u2 on q0 message", {28'b0, irq1}, 32'h4);
    wr(12'h124, 32'hFFFF_FFFF);
    #1 chk("R7 irq drops after ack", {28'b0, irq1}, 32'h0);
  endtask

  task automatic test_layout0();
    logic [31:0] d;
    do_reset();
    wr(12'h10C, 32'h0000_0004);
    wr(12'h10C, 32'h0000_0010);
    rd(12'h10C, 1, d); chk("R10 enable write replaces", d, 32'h10);
    wr(12'h048, 32'h0000_0099);
    #1 chk("R10 irq u1 layout0", {28'b0, irq0}, 32'h2);
    rd(12'h108, 1, d); chk("R10 status u1 layout0", d, 32'h10);
    wr(12'h108, 32'h0000_0010);
    rd(12'h108, 1, d); chk("R10 status cleared layout0", d, 32'h0);
    #1 chk("R10 irq cleared layout0", {28'b0, irq0}, 32'h0);
  endtask

  initial begin
    test_reset();
    test_rev_ro();
    test_order();
    test_full_empty();
    test_irq_l1();
    test_layout0();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule